// File: doc/BRIEF.md
# Wait-mode CPU clock controller

This block holds the byte-wide wait-control register of a small microcontroller and sequences the CPU clock around wait mode. Setting the wait bit stops only the gated CPU clock, one full cycle at a time. The source clock that feeds the gate, and every oscillator and peripheral clock, keep running. A peripheral interrupt request ends wait mode. The wait bit then clears in hardware and the CPU clock restarts on a full pulse.

Two fields in the register are armed before entry and act only at exit. One forces the CPU divider to no division. The other switches the clock source to the main crystal. At exit the block raises a one-cycle update strobe for the divider fields, the source fields, or both. The strobe rises in the same cycle that the clock enable returns, and the new field values for the neighbouring registers come with it. A separate stop-mode wake pulse applies the source selection only. Register writes are accepted only while the external protect-enable input is high.

Top module: `wait_clk_ctrl`

## Requirements
- R1: After reset the register reads 00h, both update strobes are low, and the CPU clock gives one pulse in every source clock cycle.
- R2: Register bits 4 down to 1 always read 0, whatever value was written.
- R3: A write made while `wr_prot_en_i` is 0 is discarded. With `wr_prot_en_i` at 1, bits 7, 6, 5 and 0 take the written value on the next edge.
- R4: Once a write sets bit 0 (wait), the CPU clock gives no pulse from the next source clock edge onward until wait mode ends. While bit 0 is 0, the clock is never stopped.
- R5: An `irq_i` high in a cycle while bit 0 is 1 clears bit 0 at that edge, and the CPU clock gives its first pulse again at the following edge. An `irq_i` high while bit 0 is 0 changes neither the register nor the strobes.
- R6: On an interrupt exit with bit 5 at 1, `div_upd_o` is high for exactly one cycle, with `div8_en_o`=0 and `div_sel_o`=00 (no division). With bit 5 at 0, `div_upd_o` stays low.
- R7: On an interrupt or stop exit with bits 7:6 = 11, `src_upd_o` is high for exactly one cycle, with `osc_run_o`=1, `xtal_pin_o`=1 and `clk_sel_o`=0 (main crystal). The codes 00, 01 and 10 keep the current source and give no strobe.
- R8: A `stop_wake_i` pulse while not in wait mode applies only the bits 7:6 selection. `div_upd_o` stays low even if bit 5 is 1.
- R9: Register writes made while in wait mode are ignored, even with protect enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock; the gate's input |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| wr_prot_en_i | input | 1 | Protect-register write-enable bit |
| reg_rdata_o | output | 8 | Register read value |
| irq_i | input | 1 | Peripheral interrupt request |
| stop_wake_i | input | 1 | One-cycle pulse marking a stop-mode exit |
| cpu_clk_o | output | 1 | Gated CPU clock |
| div_upd_o | output | 1 | One-cycle divider update strobe |
| div8_en_o | output | 1 | Divide-by-8 enable value for clock register 0 |
| div_sel_o | output | DIV_W | Divide field value for clock register 1 |
| src_upd_o | output | 1 | One-cycle clock-source update strobe |
| osc_run_o | output | 1 | Main oscillator oscillate bit value |
| xtal_pin_o | output | 1 | Crystal pin function bit value |
| clk_sel_o | output | 1 | Clock-select bit value (0 = main crystal) |

## Verification
Register writes, wait clears and both update strobes all come from one register stage. They are due one edge after the input cycle that causes them. The CPU clock stops, or starts again, at the edge after that, because the gate's latch opens only in the low phase. The bench drives inputs at falling edges and reads results at the next falling edge. It counts gated pulses in each single-cycle window, so every check falls in exactly the cycle where its register stage has settled. It sweeps all 256 write values with protect both off and on.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    typedef struct packed {
        logic [1:0] exit_src;
        logic       exit_nodiv;
        logic [3:0] rsvd;
        logic       wait_bit;
    } wcc_ctl_t;

    typedef enum logic [1:0] {
        SRC_KEEP  = 2'b00,
        SRC_RSV1  = 2'b01,
        SRC_RSV2  = 2'b10,
        SRC_XTAL  = 2'b11
    } wcc_src_e;

    localparam logic [7:0] WCC_WMASK = 8'hE1;

endpackage

// File: rtl/wcc_ctl_reg.sv
module wcc_ctl_reg
    import wcc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_en_i,
    input  logic [7:0] wdata_i,
    input  logic     clr_wait_i,
    output wcc_ctl_t ctl_o
);

    typedef struct packed {
        wcc_ctl_t ctl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ctl = wcc_ctl_t'(wdata_i & WCC_WMASK);
        end
        if (clr_wait_i) begin
            st_d.ctl.wait_bit = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctl_o = st_q.ctl;

    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ctl.rsvd == 4'b0000);  // R2

endmodule

// File: rtl/wcc_wait_seq.sv
module wcc_wait_seq
    import wcc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wait_i,
    input  logic     nodiv_i,
    input  wcc_src_e src_i,
    input  logic     irq_i,
    input  logic     stop_wake_i,
    output logic     clr_wait_o,
    output logic     div_upd_o,
    output logic     src_upd_o
);

    typedef struct packed {
        logic div_upd;
        logic src_upd;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    wake_wait, wake_stop;

    always_comb begin
        wake_wait  = wait_i & irq_i;
        wake_stop  = stop_wake_i & ~wait_i;
        st_d.div_upd = wake_wait & nodiv_i;
        st_d.src_upd = (wake_wait | wake_stop) & (src_i == SRC_XTAL);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign clr_wait_o = wake_wait;
    assign div_upd_o  = st_q.div_upd;
    assign src_upd_o  = st_q.src_upd;

    AST_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wait_i && irq_i |=> !wait_i);  // R5
    AST_DIV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_upd_o |=> !div_upd_o);  // R6
    AST_SRC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_upd_o |=> !src_upd_o);  // R7
    AST_STOP_NODIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_wake_i && !wait_i |=> !div_upd_o);  // R8

endmodule

// File: rtl/wcc_clk_gate.sv
module wcc_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/wait_clk_ctrl.sv
module wait_clk_ctrl
    import wcc_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_wr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic             wr_prot_en_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             irq_i,
    input  logic             stop_wake_i,
    output logic             cpu_clk_o,
    output logic             div_upd_o,
    output logic             div8_en_o,
    output logic [DIV_W-1:0] div_sel_o,
    output logic             src_upd_o,
    output logic             osc_run_o,
    output logic             xtal_pin_o,
    output logic             clk_sel_o
);

    localparam logic [DIV_W-1:0] DIV_NONE = '0;

    wcc_ctl_t ctl;
    logic     wr_en, clr_wait;

    assign wr_en = reg_wr_i & wr_prot_en_i & ~ctl.wait_bit;

    wcc_ctl_reg i_reg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en),
        .wdata_i    (reg_wdata_i),
        .clr_wait_i (clr_wait),
        .ctl_o      (ctl)
    );

    wcc_wait_seq i_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wait_i      (ctl.wait_bit),
        .nodiv_i     (ctl.exit_nodiv),
        .src_i       (wcc_src_e'(ctl.exit_src)),
        .irq_i       (irq_i),
        .stop_wake_i (stop_wake_i),
        .clr_wait_o  (clr_wait),
        .div_upd_o   (div_upd_o),
        .src_upd_o   (src_upd_o)
    );

    wcc_clk_gate i_gate (
        .clk_i  (clk_i),
        .en_i   (~ctl.wait_bit),
        .gclk_o (cpu_clk_o)
    );

    assign reg_rdata_o = ctl;
    assign div8_en_o   = 1'b0;
    assign div_sel_o   = DIV_NONE;
    assign osc_run_o   = 1'b1;
    assign xtal_pin_o  = 1'b1;
    assign clk_sel_o   = 1'b0;

    AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_wr_i && !wr_prot_en_i && !irq_i |=> $stable(reg_rdata_o));  // R3
    AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl.wait_bit && !irq_i |=> $stable(reg_rdata_o));  // R9

endmodule

// File: tb/test_wait_clk_ctrl.sv
`timescale 1ns/1ps
module test_wait_clk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       prot = 1'b0;
    logic [7:0] rdata;
    logic       irq = 1'b0;
    logic       stop_wake = 1'b0;
    logic       cpu_clk;
    logic       div_upd, div8_en, src_upd, osc_run, xtal_pin, clk_sel;
    logic [1:0] div_sel;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge cpu_clk) pulses = pulses + 1;

    wait_clk_ctrl #(.DIV_W(2)) i_wait_clk_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .reg_wr_i     (wr),
        .reg_wdata_i  (wdata),
        .wr_prot_en_i (prot),
        .reg_rdata_o  (rdata),
        .irq_i        (irq),
        .stop_wake_i  (stop_wake),
        .cpu_clk_o    (cpu_clk),
        .div_upd_o    (div_upd),
        .div8_en_o    (div8_en),
        .div_sel_o    (div_sel),
        .src_upd_o    (src_upd),
        .osc_run_o    (osc_run),
        .xtal_pin_o   (xtal_pin),
        .clk_sel_o    (clk_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [7:0] exp;
        logic       wt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pulses = 0;
        @(negedge clk);
        check("R1 reset value", rdata, 8'h00);
        check("R1 div strobe", div_upd, 0);
        check("R1 src strobe", src_upd, 0);
        check("R1 clock running", pulses, 1);

        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr = 1'b1; wdata = 8'h00; prot = 1'b1;
                @(negedge clk);
                wr = 1'b1; wdata = v[7:0]; prot = p[0];
                @(negedge clk);
                wr = 1'b0; prot = 1'b0;
                exp = (p == 1) ? (v[7:0] & 8'hE1) : 8'h00;
                check("R3 R2 write value", rdata, exp);
                wt = exp[0];
                pulses = 0;
                @(negedge clk);
                check("R4 clock gating", pulses, wt ? 0 : 1);
                if (wt) begin
                    wr = 1'b1; wdata = 8'h00; prot = 1'b1;
                    @(negedge clk);
                    wr = 1'b0; prot = 1'b0;
                    check("R9 write in wait", rdata, exp);
                    irq = 1'b1; pulses = 0;
                    @(negedge clk);
                    irq = 1'b0;
                    check("R5 wait cleared", rdata, exp & 8'hFE);
                    check("R5 no pulse at exit edge", pulses, 0);
                    check("R6 div strobe", div_upd, exp[5]);
                    check("R7 src strobe", src_upd, exp[7:6] == 2'b11);
                    if (div_upd) check("R6 div values", {div8_en, div_sel}, 0);
                    if (src_upd) check("R7 src values", {osc_run, xtal_pin, clk_sel}, 3'b110);
                    pulses = 0;
                    @(negedge clk);
                    check("R5 clock restarts", pulses, 1);
                    check("R6 R7 strobes single", {div_upd, src_upd}, 0);
                end else begin
                    irq = 1'b1;
                    @(negedge clk);
                    irq = 1'b0;
                    check("R5 irq outside wait", {rdata, div_upd, src_upd}, {exp, 2'b00});
                    stop_wake = 1'b1;
                    @(negedge clk);
                    stop_wake = 1'b0;
                    check("R8 stop no div", div_upd, 0);
                    check("R7 stop src strobe", src_upd, exp[7:6] == 2'b11);
                    if (src_upd) check("R7 stop src values", {osc_run, xtal_pin, clk_sel}, 3'b110);
                    @(negedge clk);
                    check("R7 stop strobe single", src_upd, 0);
                end
            end
        end
        done = 1'b1;
        summary();
    end

endmodule